// File: doc/BRIEF.md
# DMA Address Translation and Protection Unit

This block sits between bus-master devices and the memory port. Each DMA request carries a requesting device number, a byte address, a direction and write data. The block searches a small table that software fills through a configuration port. The search key is the pair of device number and page number. On a hit whose rights allow the access, the page number is replaced by the programmed physical page and the request goes on to memory. The 12-bit offset within the 4 KiB page passes through unchanged.

A request is denied when no valid entry matches or when the matching entry lacks the needed right. A denied write never reaches memory. A denied read never reaches memory either, and it returns a word of all ones. Every denied request gets an abort status.

The first denial after a clear is held in a sticky fault record until software clears it. Requests are accepted on a valid/ready handshake. The table lookup takes one cycle, and memory is issued in that cycle. Responses follow in request order, one cycle later.

Top module: `dma_xlate_unit`

## Requirements
- R1: A request accepted at clock edge k drives `mem_en` during the following cycle when it is allowed. `mem_addr` is then the entry's output page (bits 31:12) joined to the request's unchanged offset (bits 11:0).
- R2: Lookup is keyed by device number. The same address from two devices uses each device's own entry, so it can give different physical pages and different rights.
- R3: When several valid entries match the same device and page, the entry with the lowest index is used.
- R4: A read needs the entry's read right and a write needs its write right. A denied request of either direction leaves `mem_en` and `mem_we` low in its lookup cycle.
- R5: A denied read responds with `rsp_data` all ones and `rsp_abort` = 1.
- R6: A request with no matching valid entry is denied, and it gets the same response as a rights failure.
- R7: Each accepted request gets exactly one response, two cycles after acceptance and in request order. An allowed read returns the memory word with `rsp_abort` = 0. An allowed write returns zero data with `rsp_abort` = 0. A denied write returns all ones with `rsp_abort` = 1.
- R8: If the fault record is empty, the first denied request fills it with device, address and direction (`flt_write` = 1 for a write). The record is then valid from the cycle after the lookup. While it is valid, later denials do not change it.
- R9: `cfg_fault_clr` empties the fault record. When a denial is looked up in the same cycle as the clear, that denial is captured and the record stays valid with the new contents.
- R10: A table write (`cfg_we`) loads entry `cfg_idx` at the clock edge. `req_ready` is low in every cycle where `cfg_we` is high. After reset every entry is invalid.
- R11: During reset `rsp_valid`, `mem_en` and `flt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_dev | input | 8 | Requesting device number |
| req_addr | input | 32 | Device-visible byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_abort | output | 1 | 1 = request was denied |
| rsp_data | output | 32 | Read data, zero for an allowed write, all ones when denied |
| mem_en | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Translated physical address |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_en |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 4 | Entry index |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_dev | input | 8 | Entry device number |
| cfg_ipage | input | 20 | Entry input page |
| cfg_opage | input | 20 | Entry output page |
| cfg_rd | input | 1 | Entry read right |
| cfg_wr | input | 1 | Entry write right |
| cfg_fault_clr | input | 1 | Clear the fault record |
| flt_valid | output | 1 | Fault record holds a denial |
| flt_dev | output | 8 | Device number of recorded denial |
| flt_addr | output | 32 | Address of recorded denial |
| flt_write | output | 1 | Direction of recorded denial |

## Verification
Two things can happen in the same cycle: software clears the fault record while a denied request is in its lookup cycle. The bench sets up this case directly. It first fills the record with one denial. It then raises `cfg_fault_clr` in exactly the lookup cycle of a second denial from another device. The next cycle must show the record valid and holding the second request's device, address and direction. Random traffic also mixes clears, table rewrites and denials, and a cycle-level bench model of the table and the fault record judges every cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  // Access right test for one table entry
  function automatic logic perm_ok(input logic is_wr, input logic rd_en, input logic wr_en);
    return is_wr ? wr_en : rd_en;
  endfunction

endpackage

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int N_ENT  = 16,
  parameter int DEV_W  = 8,
  parameter int PAGE_W = 20,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [PAGE_W-1:0] cfg_ipage,
  input  logic [PAGE_W-1:0] cfg_opage,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [DEV_W-1:0]  lk_dev,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              lk_hit,
  output logic [PAGE_W-1:0] lk_opage,
  output logic              lk_rd,
  output logic              lk_wr
);

  logic [N_ENT-1:0]  ent_vld;
  logic [DEV_W-1:0]  ent_dev [N_ENT];
  logic [PAGE_W-1:0] ent_ip  [N_ENT];
  logic [PAGE_W-1:0] ent_op  [N_ENT];
  logic [N_ENT-1:0]  ent_rd;
  logic [N_ENT-1:0]  ent_wr;
  logic [N_ENT-1:0]  match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic load;
    assign load = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
      end else if (load) begin
        ent_vld[g] <= cfg_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (load) begin
        ent_dev[g] <= cfg_dev;
        ent_ip[g]  <= cfg_ipage;
        ent_op[g]  <= cfg_opage;
        ent_rd[g]  <= cfg_rd;
        ent_wr[g]  <= cfg_wr;
      end
    end

    assign match[g] = ent_vld[g] && (ent_dev[g] == lk_dev) && (ent_ip[g] == lk_page);
  end

  // Priority pick: lowest index wins
  logic [IDX_W-1:0] sel;
  always_comb begin
    lk_hit = 1'b0;
    sel    = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        sel    = IDX_W'(i);
      end
    end
  end

  assign lk_opage = ent_op[sel];
  assign lk_rd    = ent_rd[sel];
  assign lk_wr    = ent_wr[sel];

  // R10
  ent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ent_vld[$past(cfg_idx)] == $past(cfg_valid));

endmodule

// File: rtl/xlate_fault_log.sv
module xlate_fault_log #(
  parameter int DEV_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [DEV_W-1:0]  evt_dev,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_write,
  input  logic              clr,
  output logic              flt_valid,
  output logic [DEV_W-1:0]  flt_dev,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write
);

  logic valid_d;
  logic cap_en;

  always_comb begin
    cap_en  = evt && (!flt_valid || clr);
    valid_d = flt_valid;
    if (clr)    valid_d = 1'b0;
    if (cap_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
    end else begin
      flt_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      flt_dev   <= evt_dev;
      flt_addr  <= evt_addr;
      flt_write <= evt_write;
    end
  end

  // R8
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !clr |=> flt_valid && $stable(flt_addr) && $stable(flt_dev));

  // R9
  flt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !evt |=> !flt_valid);

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
  parameter int DEV_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  parameter int N_ENT  = 16,
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [PAGE_W-1:0] cfg_ipage,
  input  logic [PAGE_W-1:0] cfg_opage,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic              cfg_fault_clr,
  output logic              flt_valid,
  output logic [DEV_W-1:0]  flt_dev,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write
);

  import xlate_pkg::*;

  // Stage 1: accepted request, lookup cycle
  logic              acc;
  logic              s1_vld;
  logic [DEV_W-1:0]  s1_dev;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_write;
  logic [DATA_W-1:0] s1_wdata;

  assign req_ready = !cfg_we;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= acc;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s1_dev   <= req_dev;
      s1_addr  <= req_addr;
      s1_write <= req_write;
      s1_wdata <= req_wdata;
    end
  end

  logic              lk_hit;
  logic [PAGE_W-1:0] lk_opage;
  logic              lk_rd;
  logic              lk_wr;

  xlate_table #(
    .N_ENT (N_ENT),
    .DEV_W (DEV_W),
    .PAGE_W(PAGE_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_valid(cfg_valid),
    .cfg_dev  (cfg_dev),
    .cfg_ipage(cfg_ipage),
    .cfg_opage(cfg_opage),
    .cfg_rd   (cfg_rd),
    .cfg_wr   (cfg_wr),
    .lk_dev   (s1_dev),
    .lk_page  (s1_addr[ADDR_W-1:OFS_W]),
    .lk_hit   (lk_hit),
    .lk_opage (lk_opage),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr)
  );

  logic allow;
  assign allow = lk_hit && perm_ok(s1_write, lk_rd, lk_wr);

  assign mem_en    = s1_vld && allow;
  assign mem_we    = mem_en && (dir_e'(s1_write) == DIR_WRITE);
  assign mem_addr  = {lk_opage, s1_addr[OFS_W-1:0]};
  assign mem_wdata = s1_wdata;

  xlate_fault_log #(
    .DEV_W (DEV_W),
    .ADDR_W(ADDR_W)
  ) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (s1_vld && !allow),
    .evt_dev  (s1_dev),
    .evt_addr (s1_addr),
    .evt_write(s1_write),
    .clr      (cfg_fault_clr),
    .flt_valid(flt_valid),
    .flt_dev  (flt_dev),
    .flt_addr (flt_addr),
    .flt_write(flt_write)
  );

  // Stage 2: response
  logic s2_vld;
  logic s2_allow;
  logic s2_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_allow <= allow;
      s2_write <= s1_write;
    end
  end

  assign rsp_valid = s2_vld;
  assign rsp_abort = !s2_allow;
  assign rsp_data  = !s2_allow ? '1 : (s2_write ? '0 : mem_rdata);

  // R4
  deny_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_abort |-> !$past(mem_en));

  // R7
  rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready, 2));

  // R1
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !rsp_valid && !mem_en && !flt_valid);

endmodule

// File: tb/sim_dma_xlate_unit.sv
`timescale 1ns/1ps
module sim_dma_xlate_unit;

  localparam logic [31:0] KEY = 32'h5A5A_C3C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_dev;
  logic [31:0] req_addr;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_abort;
  logic [31:0] rsp_data;
  logic        mem_en;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic        cfg_valid;
  logic [7:0]  cfg_dev;
  logic [19:0] cfg_ipage;
  logic [19:0] cfg_opage;
  logic        cfg_rd;
  logic        cfg_wr;
  logic        cfg_fault_clr;
  logic        flt_valid;
  logic [7:0]  flt_dev;
  logic [31:0] flt_addr;
  logic        flt_write;

  always #2 clk = ~clk;

  dma_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_dev(cfg_dev), .cfg_ipage(cfg_ipage), .cfg_opage(cfg_opage),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_fault_clr(cfg_fault_clr),
    .flt_valid(flt_valid), .flt_dev(flt_dev), .flt_addr(flt_addr),
    .flt_write(flt_write)
  );

  // Memory model: read word is a fixed function of the address
  always @(posedge clk) if (mem_en) mem_rdata <= mem_addr ^ KEY;

  int errors = 0;
  int checks = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench table and fault models
  logic        bt_v  [16];
  logic [7:0]  bt_dev[16];
  logic [19:0] bt_ip [16];
  logic [19:0] bt_op [16];
  logic        bt_r  [16];
  logic        bt_w  [16];

  logic        st1_v, st1_wr;
  logic [7:0]  st1_dev;
  logic [31:0] st1_addr;
  logic        p_allow;
  logic [31:0] p_addr;
  logic        st2_v, st2_allow;
  logic [31:0] st2_data;
  logic        fm_v, fm_wr;
  logic [7:0]  fm_dev;
  logic [31:0] fm_addr;

  function automatic int find(input logic [7:0] dev, input logic [19:0] pg);
    int hit = -1;
    for (int i = 15; i >= 0; i--)
      if (bt_v[i] && bt_dev[i] == dev && bt_ip[i] == pg) hit = i;
    return hit;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bt_v[i] = 1'b0;
      st1_v = 1'b0; st2_v = 1'b0; fm_v = 1'b0;
      p_allow = 1'b0;
    end else begin
      if (cfg_fault_clr) fm_v = 1'b0;
      if (st1_v && !p_allow && !fm_v) begin
        fm_v = 1'b1; fm_dev = st1_dev; fm_addr = st1_addr; fm_wr = st1_wr;
      end
      st2_v     = st1_v;
      st2_allow = p_allow;
      st2_data  = !p_allow ? 32'hFFFF_FFFF : (st1_wr ? 32'h0 : (p_addr ^ KEY));
      if (cfg_we) begin
        bt_v[cfg_idx] = cfg_valid; bt_dev[cfg_idx] = cfg_dev;
        bt_ip[cfg_idx] = cfg_ipage; bt_op[cfg_idx] = cfg_opage;
        bt_r[cfg_idx] = cfg_rd; bt_w[cfg_idx] = cfg_wr;
      end
      st1_v    = req_valid && !cfg_we;
      st1_dev  = req_dev;
      st1_addr = req_addr;
      st1_wr   = req_write;
    end
  end

  // Cycle monitor: compare ports with the bench model
  always @(negedge clk) begin
    if (rst_n) begin
      int h;
      h = find(st1_dev, st1_addr[31:12]);
      p_allow = st1_v && (h >= 0) && (st1_wr ? bt_w[h] : bt_r[h]);
      p_addr  = (h >= 0) ? {bt_op[h], st1_addr[11:0]} : 32'h0;
      chk(req_ready == !cfg_we, "R10 ready", req_ready, !cfg_we);
      chk(mem_en == p_allow, "R4 mem_en", mem_en, p_allow);
      if (p_allow) begin
        chk(mem_addr == p_addr, "R1 mem_addr", mem_addr, p_addr);
        chk(mem_we == st1_wr, "R4 mem_we", mem_we, st1_wr);
      end else begin
        chk(!mem_we, "R4 mem_we denied", mem_we, 0);
      end
      chk(rsp_valid == st2_v, "R7 rsp_valid", rsp_valid, st2_v);
      if (st2_v) begin
        chk(rsp_abort == !st2_allow, st2_allow ? "R7 status" : "R5 status", rsp_abort, !st2_allow);
        chk(rsp_data == st2_data, st2_allow ? "R7 data" : "R5 data", rsp_data, st2_data);
      end
      chk(flt_valid == fm_v, "R8 flt_valid", flt_valid, fm_v);
      if (fm_v)
        chk(flt_dev == fm_dev && flt_addr == fm_addr && flt_write == fm_wr,
            "R8 flt record", {flt_dev, flt_addr}, {fm_dev, fm_addr});
    end
  end

  logic        d_en, d_we, d_abort;
  logic [31:0] d_addr, d_data;

  task automatic go(input logic [7:0] dev, input logic [31:0] addr, input logic wr);
    @(posedge clk); #1;
    req_valid = 1'b1; req_dev = dev; req_addr = addr; req_write = wr; req_wdata = 32'hCAFE_0000 | addr[15:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    d_en = mem_en; d_we = mem_we; d_addr = mem_addr;
    @(negedge clk);
    d_abort = rsp_abort; d_data = rsp_data;
  endtask

  task automatic cfgw(input logic [3:0] idx, input logic v, input logic [7:0] dev,
                      input logic [19:0] ip, input logic [19:0] op, input logic r, input logic w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_dev = dev;
    cfg_ipage = ip; cfg_opage = op; cfg_rd = r; cfg_wr = w;
    @(negedge clk);
    chk(!req_ready, "R10 ready during table write", req_ready, 0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] pick_dev(input int k);
    case (k % 5)
      0: return 8'd3;
      1: return 8'd4;
      2: return 8'd7;
      3: return 8'd9;
      default: return 8'd5;
    endcase
  endfunction

  function automatic logic [19:0] pick_pg(input int k);
    case (k % 4)
      0: return 20'h00010;
      1: return 20'h00022;
      2: return 20'h00040;
      default: return 20'h00033;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 0; req_dev = 0; req_addr = 0; req_write = 0; req_wdata = 0;
    cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_dev = 0; cfg_ipage = 0; cfg_opage = 0;
    cfg_rd = 0; cfg_wr = 0; cfg_fault_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!rsp_valid && !mem_en && !flt_valid, "R11 reset outputs", {rsp_valid, mem_en, flt_valid}, 0);
    rst_n = 1'b1;

    // R10/R6: empty table after reset denies everything
    go(8'd3, 32'h0001_0ABC, 1'b0);
    chk(!d_en, "R10 empty table no access", d_en, 0);
    chk(d_abort && d_data == 32'hFFFF_FFFF, "R6 miss response", {d_abort, d_data}, {1'b1, 32'hFFFF_FFFF});
    @(negedge clk);
    chk(flt_valid && flt_dev == 8'd3 && flt_addr == 32'h0001_0ABC && !flt_write,
        "R8 first fault", {flt_dev, flt_addr}, {8'd3, 32'h0001_0ABC});

    cfgw(4'd0, 1, 8'd3, 20'h00010, 20'h0ABCD, 1, 1);
    cfgw(4'd1, 1, 8'd4, 20'h00010, 20'h01234, 1, 0);
    cfgw(4'd5, 1, 8'd7, 20'h00022, 20'h00555, 1, 1);
    cfgw(4'd9, 1, 8'd7, 20'h00022, 20'h00999, 1, 1);
    cfgw(4'd2, 0, 8'd9, 20'h00040, 20'h00777, 1, 1);

    go(8'd3, 32'h0001_0ABC, 1'b0);
    chk(d_en && d_addr == 32'h0ABC_DABC, "R1 translated read", d_addr, 32'h0ABC_DABC);
    chk(!d_abort && d_data == (32'h0ABC_DABC ^ KEY), "R7 read data", d_data, 32'h0ABC_DABC ^ KEY);

    go(8'd4, 32'h0001_0ABC, 1'b0);
    chk(d_en && d_addr == 32'h0123_4ABC, "R2 per-device page", d_addr, 32'h0123_4ABC);

    go(8'd4, 32'h0001_0FF0, 1'b1);
    chk(!d_en && !d_we, "R4 write without right", {d_en, d_we}, 0);
    chk(d_abort && d_data == 32'hFFFF_FFFF, "R4 write abort", {d_abort, d_data}, {1'b1, 32'hFFFF_FFFF});
    @(negedge clk);
    chk(flt_dev == 8'd3 && flt_addr == 32'h0001_0ABC, "R8 sticky record", {flt_dev, flt_addr}, {8'd3, 32'h0001_0ABC});

    go(8'd7, 32'h0002_2004, 1'b1);
    chk(d_en && d_we && d_addr == 32'h0055_5004, "R3 lowest index wins", d_addr, 32'h0055_5004);
    chk(!d_abort && d_data == 32'h0, "R7 write okay", {d_abort, d_data}, 0);

    go(8'd9, 32'h0004_0000, 1'b0);
    chk(!d_en && d_abort && d_data == 32'hFFFF_FFFF, "R6 invalid entry denied", {d_en, d_abort, d_data}, {1'b0, 1'b1, 32'hFFFF_FFFF});

    // R9: clear alone
    @(posedge clk); #1; cfg_fault_clr = 1'b1;
    @(posedge clk); #1; cfg_fault_clr = 1'b0;
    @(negedge clk);
    chk(!flt_valid, "R9 clear", flt_valid, 0);
    go(8'd9, 32'h0004_0010, 1'b0);
    @(negedge clk);
    chk(flt_valid && flt_dev == 8'd9, "R9 refill after clear", flt_dev, 8'd9);

    // R9: clear in the lookup cycle of a new denial
    @(posedge clk); #1;
    req_valid = 1'b1; req_dev = 8'd4; req_addr = 32'h0001_0008; req_write = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_fault_clr = 1'b1;
    @(posedge clk); #1;
    cfg_fault_clr = 1'b0;
    @(negedge clk);
    chk(flt_valid && flt_dev == 8'd4 && flt_addr == 32'h0001_0008 && flt_write,
        "R9 clear with same-cycle denial", {flt_valid, flt_dev, flt_addr}, {1'b1, 8'd4, 32'h0001_0008});

    // Random traffic, judged by the cycle monitor
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      req_valid = ($urandom % 3) != 0;
      req_dev   = pick_dev($urandom);
      req_addr  = {pick_pg($urandom), 12'($urandom)};
      req_write = $urandom % 2;
      req_wdata = $urandom;
      cfg_we    = ($urandom % 20) == 0;
      cfg_idx   = 4'($urandom);
      cfg_valid = ($urandom % 4) != 0;
      cfg_dev   = pick_dev($urandom);
      cfg_ipage = pick_pg($urandom);
      cfg_opage = 20'($urandom);
      cfg_rd    = $urandom % 2;
      cfg_wr    = $urandom % 2;
      cfg_fault_clr = ($urandom % 25) == 0;
    end
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0; cfg_fault_clr = 0;
    repeat (3) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule